// File: doc/BRIEF.md
# Integer Execute Unit with Carry and Compare Flags

This block is the integer execute stage of a 32-bit RISC pipeline. Each cycle it receives the raw 32-bit instruction word and the two register operands already read from the register file. It decodes the instruction, picks the second operand (register value or an extended 16-bit immediate), and computes a 32-bit result. It also asserts a register write enable when the instruction produces a general-register result.

Two single-bit status flags live inside the block. The carry bit is written by the add family and is consumed as a carry-in by add-with-carry. The compare flag is written only by the set-flag compares, which produce no register result. Both flags change only on a clock edge where the execute-valid strobe is high, so a stalled or bubbled cycle leaves them untouched. Fetch, the register file, memory access and exceptions belong to neighbouring blocks.

The reset input clears the flags at once. Its release is re-timed through two flops, so the flags leave reset two clock edges after the input goes high.

Top module: `int_exec_unit`

## Requirements
- R1: After reset, `carry` and `flag` are both 0.
- R2: Major opcode `instr[31:26]=0x38` with `{instr[9:8],instr[3:0]}` = 0/0 (add) or 0/1 (add-with-carry) gives `result = opa + opb (+ carry for 0/1)`. Major 0x27 (add-immediate) gives `opa + sign-extended instr[15:0]`. All three load `carry` with the unsigned carry out of bit 31.
- R3: Subtract (0x38, 0/2) gives `result = opa - opb` and leaves `carry` unchanged.
- R4: Under 0x38, selector 0/3 gives AND, 0/4 gives OR and 0/5 gives XOR of `opa` and `opb`.
- R5: The immediate in `instr[15:0]` is zero-extended for AND-immediate (0x29) and OR-immediate (0x2a), and sign-extended for XOR-immediate (0x2b) and add-immediate (0x27).
- R6: Under 0x38, selector 0/8 shifts left, 1/8 shifts right logically and 2/8 shifts right arithmetically. The amount is `opb[4:0]` only. The logical shifts fill with zeros and the arithmetic shift fills with `opa[31]`.
- R7: Load-high-immediate (major 0x06) gives `result = {instr[15:0], 16'h0000}`.
- R8: A register compare is `instr[31:25]=0x72`, with the condition in `instr[24:21]`: 0=eq, 1=ne, 2=gtu, 3=geu, 4=ltu, 5=leu, A=gts, B=ges, C=lts, D=les. It sets `flag` when `opa` relates to `opb` as coded, and clears `flag` otherwise.
- R9: An immediate compare is `instr[31:25]=0x5e`, with the same condition codes. It compares `opa` with the sign-extended `instr[15:0]`, and this holds for the unsigned conditions too.
- R10: Compares keep `rd_we` low and leave `carry` unchanged. Every non-compare instruction leaves `flag` unchanged.
- R11: When `exe_valid` is low, neither flag changes and `rd_we` is low.
- R12: An unlisted encoding, including compare condition codes 6 to 9, E and F, keeps `rd_we` low and leaves both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| exe_valid | input | 1 | Instruction in this cycle is real; gates flag updates and write enable |
| instr | input | 32 | Raw instruction word |
| opa | input | 32 | First source register value |
| opb | input | 32 | Second source register value |
| result | output | 32 | Computed result for the destination register |
| rd_we | output | 1 | Destination register write enable |
| carry | output | 1 | Registered carry bit |
| flag | output | 1 | Registered compare flag |

## Verification
Random operands run against every listed encoding and against fully random instruction words. This separates correct decoding from accidental aliasing of the selector fields and the compare condition nibble. Operand pairs are skewed toward equal values, all-ones values and sign-bit patterns. These patterns make signed and unsigned orderings disagree, so swapped or mis-signed compares show up. Chained add-with-carry after a carry-producing add shows whether the carry-in comes from the registered bit. Cycles with the valid strobe low, and shift amounts with bit 5 set, show that stalls and the upper bits of the shift amount have no effect.

// File: rtl/iexu_pkg.sv
package iexu_pkg;
  localparam int unsigned XW    = 32;
  localparam int unsigned IMM_W = 16;
  localparam int unsigned SHW   = $clog2(XW);
  localparam int unsigned PAD_W = XW - IMM_W;

  localparam logic [5:0] MAJ_RR    = 6'h38;
  localparam logic [5:0] MAJ_ADDI  = 6'h27;
  localparam logic [5:0] MAJ_ANDI  = 6'h29;
  localparam logic [5:0] MAJ_ORI   = 6'h2a;
  localparam logic [5:0] MAJ_XORI  = 6'h2b;
  localparam logic [5:0] MAJ_MOVHI = 6'h06;
  localparam logic [6:0] CMP_REG   = 7'h72;
  localparam logic [6:0] CMP_IMM   = 7'h5e;

  typedef enum logic [3:0] {
    OP_NONE, OP_ADD, OP_ADDC, OP_SUB, OP_AND, OP_OR, OP_XOR,
    OP_SLL, OP_SRL, OP_SRA, OP_PASSB, OP_CMP
  } alu_op_e;

  typedef enum logic [3:0] {
    CC_EQ  = 4'h0, CC_NE  = 4'h1, CC_GTU = 4'h2, CC_GEU = 4'h3,
    CC_LTU = 4'h4, CC_LEU = 4'h5, CC_GTS = 4'ha, CC_GES = 4'hb,
    CC_LTS = 4'hc, CC_LES = 4'hd
  } cmp_cond_e;

  typedef struct packed {
    alu_op_e   op;
    cmp_cond_e cond;
    logic      wr_reg;
    logic      upd_cy;
    logic      upd_f;
  } ctl_t;
endpackage

// File: rtl/iexu_decode.sv
module iexu_decode
  import iexu_pkg::*;
(
  input  logic [31:0]   instr,
  input  logic [XW-1:0] opb,
  output ctl_t          ctl,
  output logic [XW-1:0] opnd_b
);
  logic [IMM_W-1:0] imm;
  logic [XW-1:0]    imm_sx;
  logic [XW-1:0]    imm_zx;
  logic [5:0]       major;
  logic [5:0]       rr_sel;
  logic [3:0]       cc;
  logic             cc_ok;

  assign imm    = instr[IMM_W-1:0];
  assign imm_sx = {{PAD_W{imm[IMM_W-1]}}, imm};
  assign imm_zx = {{PAD_W{1'b0}}, imm};
  assign major  = instr[31:26];
  assign rr_sel = {instr[9:8], instr[3:0]};
  assign cc     = instr[24:21];
  assign cc_ok  = (cc <= 4'h5) || ((cc >= 4'ha) && (cc <= 4'hd));

  always_comb begin
    ctl    = '{op: OP_NONE, cond: CC_EQ, wr_reg: 1'b0, upd_cy: 1'b0, upd_f: 1'b0};
    opnd_b = opb;
    if ((instr[31:25] == CMP_REG) && cc_ok) begin
      ctl.op    = OP_CMP;
      ctl.cond  = cmp_cond_e'(cc);
      ctl.upd_f = 1'b1;
    end else if ((instr[31:25] == CMP_IMM) && cc_ok) begin
      ctl.op    = OP_CMP;
      ctl.cond  = cmp_cond_e'(cc);
      ctl.upd_f = 1'b1;
      opnd_b    = imm_sx;
    end else begin
      unique case (major)
        MAJ_RR: begin
          ctl.wr_reg = 1'b1;
          case (rr_sel)
            6'h00:   begin ctl.op = OP_ADD;  ctl.upd_cy = 1'b1; end
            6'h01:   begin ctl.op = OP_ADDC; ctl.upd_cy = 1'b1; end
            6'h02:   ctl.op = OP_SUB;
            6'h03:   ctl.op = OP_AND;
            6'h04:   ctl.op = OP_OR;
            6'h05:   ctl.op = OP_XOR;
            6'h08:   ctl.op = OP_SLL;
            6'h18:   ctl.op = OP_SRL;
            6'h28:   ctl.op = OP_SRA;
            default: ctl.wr_reg = 1'b0;
          endcase
        end
        MAJ_ADDI: begin
          ctl.op = OP_ADD; ctl.wr_reg = 1'b1; ctl.upd_cy = 1'b1; opnd_b = imm_sx;
        end
        MAJ_ANDI: begin ctl.op = OP_AND; ctl.wr_reg = 1'b1; opnd_b = imm_zx; end
        MAJ_ORI:  begin ctl.op = OP_OR;  ctl.wr_reg = 1'b1; opnd_b = imm_zx; end
        MAJ_XORI: begin ctl.op = OP_XOR; ctl.wr_reg = 1'b1; opnd_b = imm_sx; end
        MAJ_MOVHI: begin
          ctl.op = OP_PASSB; ctl.wr_reg = 1'b1; opnd_b = {imm, {PAD_W{1'b0}}};
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iexu_cmp.sv
module iexu_cmp
  import iexu_pkg::*;
(
  input  cmp_cond_e     cond,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  output logic          holds
);
  logic eq, lt_u, lt_s;

  assign eq   = (a == b);
  assign lt_u = (a < b);
  assign lt_s = ($signed(a) < $signed(b));

  always_comb begin
    unique case (cond)
      CC_EQ:   holds = eq;
      CC_NE:   holds = !eq;
      CC_GTU:  holds = !lt_u && !eq;
      CC_GEU:  holds = !lt_u;
      CC_LTU:  holds = lt_u;
      CC_LEU:  holds = lt_u || eq;
      CC_GTS:  holds = !lt_s && !eq;
      CC_GES:  holds = !lt_s;
      CC_LTS:  holds = lt_s;
      CC_LES:  holds = lt_s || eq;
      default: holds = 1'b0;
    endcase
  end
endmodule

// File: rtl/iexu_alu.sv
module iexu_alu
  import iexu_pkg::*;
(
  input  alu_op_e       op,
  input  logic [XW-1:0] a,
  input  logic [XW-1:0] b,
  input  logic          cin,
  output logic [XW-1:0] res,
  output logic          cout
);
  logic [XW:0]    sum_w;
  logic           cin_eff;
  logic [SHW-1:0] amt;

  assign cin_eff = (op == OP_ADDC) ? cin : 1'b0;
  assign sum_w   = {1'b0, a} + {1'b0, b} + {{XW{1'b0}}, cin_eff};
  assign cout    = sum_w[XW];
  assign amt     = b[SHW-1:0];

  always_comb begin
    unique case (op)
      OP_ADD, OP_ADDC: res = sum_w[XW-1:0];
      OP_SUB:          res = a - b;
      OP_AND:          res = a & b;
      OP_OR:           res = a | b;
      OP_XOR:          res = a ^ b;
      OP_SLL:          res = a << amt;
      OP_SRL:          res = a >> amt;
      OP_SRA:          res = $unsigned($signed(a) >>> amt);
      OP_PASSB:        res = b;
      default:         res = '0;
    endcase
  end
endmodule

// File: rtl/iexu_flags.sv
module iexu_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic upd_cy,
  input  logic cy_d,
  input  logic upd_f,
  input  logic f_d,
  output logic cy_q,
  output logic f_q
);
  logic cy_nxt, f_nxt;

  always_comb begin
    cy_nxt = cy_q;
    f_nxt  = f_q;
    if (en && upd_cy) cy_nxt = cy_d;
    if (en && upd_f)  f_nxt  = f_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cy_q <= 1'b0;
      f_q  <= 1'b0;
    end else begin
      cy_q <= cy_nxt;
      f_q  <= f_nxt;
    end
  end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iexu_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exe_valid,
  input  logic [31:0]   instr,
  input  logic [XW-1:0] opa,
  input  logic [XW-1:0] opb,
  output logic [XW-1:0] result,
  output logic          rd_we,
  output logic          carry,
  output logic          flag
);
  logic [1:0]    rst_sync;
  logic          rst_int_n;
  ctl_t          ctl;
  logic [XW-1:0] opnd_b;
  logic          alu_cout;
  logic          cmp_holds;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  iexu_decode i_decode (
    .instr (instr),
    .opb   (opb),
    .ctl   (ctl),
    .opnd_b(opnd_b)
  );

  iexu_alu i_alu (
    .op  (ctl.op),
    .a   (opa),
    .b   (opnd_b),
    .cin (carry),
    .res (result),
    .cout(alu_cout)
  );

  iexu_cmp i_cmp (
    .cond (ctl.cond),
    .a    (opa),
    .b    (opnd_b),
    .holds(cmp_holds)
  );

  iexu_flags i_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .en    (exe_valid),
    .upd_cy(ctl.upd_cy),
    .cy_d  (alu_cout),
    .upd_f (ctl.upd_f),
    .f_d   (cmp_holds),
    .cy_q  (carry),
    .f_q   (flag)
  );

  assign rd_we = exe_valid & ctl.wr_reg;
endmodule

// File: rtl/iexu_chk.sv
module iexu_chk
  import iexu_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          exe_valid,
  input logic [31:0]   instr,
  input logic [XW-1:0] opa,
  input logic [XW-1:0] opb,
  input logic [XW-1:0] result,
  input logic          rd_we,
  input logic          carry,
  input logic          flag
);
  logic is_cmp, is_sub, is_add, is_movhi;

  assign is_cmp   = (instr[31:25] == CMP_REG) || (instr[31:25] == CMP_IMM);
  assign is_sub   = (instr[31:26] == MAJ_RR) && ({instr[9:8], instr[3:0]} == 6'h02);
  assign is_add   = (instr[31:26] == MAJ_RR) && ({instr[9:8], instr[3:0]} == 6'h00);
  assign is_movhi = (instr[31:26] == MAJ_MOVHI);

  AST_IDLE_HOLDS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !exe_valid |=> $stable(carry) && $stable(flag)); // R11
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && is_cmp |-> !rd_we); // R10
  AST_CMP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && is_cmp |=> $stable(carry)); // R10
  AST_OTHER_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && !is_cmp |=> $stable(flag)); // R10
  AST_SUB_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && is_sub |=> $stable(carry)); // R3
  AST_ADD_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && is_add |-> rd_we && (result == opa + opb)); // R2
  AST_MOVHI_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    exe_valid && is_movhi |-> rd_we && (result[15:0] == 16'h0000)); // R7
endmodule

bind int_exec_unit iexu_chk i_chk (.*);

// File: tb/test_int_exec_unit.sv
module test_int_exec_unit;
  localparam time CLK_P = 20ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exe_valid;
  logic [31:0] instr, opa, opb;
  logic [31:0] result;
  logic        rd_we, carry, flag;

  int n_chk  = 0;
  int n_fail = 0;
  logic m_cy = 1'b0;
  logic m_f  = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  int_exec_unit i_int_exec_unit (
    .clk(clk), .rst_n(rst_n), .exe_valid(exe_valid), .instr(instr),
    .opa(opa), .opb(opb), .result(result), .rd_we(rd_we),
    .carry(carry), .flag(flag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: instr=%h got %h expected %h", req, instr, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic cy, input logic f,
                       output logic [31:0] r, output logic wr, output logic ncy,
                       output logic nf, output string tr, output string tc, output string tf);
    logic [31:0] se, ze, bb;
    logic [32:0] t;
    logic [3:0]  nib;
    logic        nib_ok;
    se = {{16{ins[15]}}, ins[15:0]};
    ze = {16'h0, ins[15:0]};
    nib = ins[24:21];
    nib_ok = (nib <= 4'h5) || (nib >= 4'ha && nib <= 4'hd);
    r = 32'h0; wr = 1'b0; ncy = cy; nf = f;
    tr = "R12"; tc = "R12"; tf = "R12";
    if ((ins[31:25] == 7'h72 || ins[31:25] == 7'h5e) && nib_ok) begin
      bb = (ins[31:25] == 7'h72) ? b : se;
      case (nib)
        4'h0: nf = (a == bb);
        4'h1: nf = (a != bb);
        4'h2: nf = (a > bb);
        4'h3: nf = (a >= bb);
        4'h4: nf = (a < bb);
        4'h5: nf = (a <= bb);
        4'ha: nf = ($signed(a) > $signed(bb));
        4'hb: nf = ($signed(a) >= $signed(bb));
        4'hc: nf = ($signed(a) < $signed(bb));
        default: nf = ($signed(a) <= $signed(bb));
      endcase
      tf = (ins[31:25] == 7'h72) ? "R8" : "R9";
      tr = "R10"; tc = "R10";
    end else begin
      tf = "R10";
      case (ins[31:26])
        6'h38: begin
          wr = 1'b1; tc = "R10";
          case ({ins[9:8], ins[3:0]})
            6'h00: begin t = {1'b0, a} + {1'b0, b};       r = t[31:0]; ncy = t[32]; tr = "R2"; tc = "R2"; end
            6'h01: begin t = {1'b0, a} + {1'b0, b} + cy;  r = t[31:0]; ncy = t[32]; tr = "R2"; tc = "R2"; end
            6'h02: begin r = a - b; tr = "R3"; tc = "R3"; end
            6'h03: begin r = a & b; tr = "R4"; end
            6'h04: begin r = a | b; tr = "R4"; end
            6'h05: begin r = a ^ b; tr = "R4"; end
            6'h08: begin r = a << b[4:0]; tr = "R6"; end
            6'h18: begin r = a >> b[4:0]; tr = "R6"; end
            6'h28: begin r = $unsigned($signed(a) >>> b[4:0]); tr = "R6"; end
            default: begin wr = 1'b0; tr = "R12"; tc = "R12"; tf = "R12"; end
          endcase
        end
        6'h27: begin t = {1'b0, a} + {1'b0, se}; r = t[31:0]; ncy = t[32]; wr = 1'b1; tr = "R5"; tc = "R2"; end
        6'h29: begin r = a & ze; wr = 1'b1; tr = "R5"; tc = "R10"; end
        6'h2a: begin r = a | ze; wr = 1'b1; tr = "R5"; tc = "R10"; end
        6'h2b: begin r = a ^ se; wr = 1'b1; tr = "R5"; tc = "R10"; end
        6'h06: begin r = {ins[15:0], 16'h0}; wr = 1'b1; tr = "R7"; tc = "R10"; end
        default: begin tf = "R12"; end
      endcase
    end
  endtask

  task automatic apply(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b, input logic v);
    logic [31:0] er;
    logic ew, ecy, ef;
    string tr, tc, tf;
    @(negedge clk);
    instr = ins; opa = a; opb = b; exe_valid = v;
    model(ins, a, b, m_cy, m_f, er, ew, ecy, ef, tr, tc, tf);
    if (!v) begin ecy = m_cy; ef = m_f; tc = "R11"; tf = "R11"; end
    #2;
    if (ew) check(tr, result, er);
    check(v ? tr : "R11", {31'h0, rd_we}, {31'h0, v && ew});
    @(posedge clk);
    #2;
    m_cy = ecy; m_f = ef;
    check(tc, {31'h0, carry}, {31'h0, ecy});
    check(tf, {31'h0, flag}, {31'h0, ef});
  endtask

  function automatic logic [31:0] rr(input logic [1:0] hi, input logic [3:0] lo);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = 6'h38; w[9:8] = hi; w[3:0] = lo;
    return w;
  endfunction

  function automatic logic [31:0] immop(input logic [5:0] maj, input logic [15:0] imm);
    logic [31:0] w;
    w = $urandom;
    w[31:26] = maj; w[15:0] = imm;
    return w;
  endfunction

  function automatic logic [31:0] cmpop(input logic [6:0] hi, input logic [3:0] cc, input logic [15:0] imm);
    logic [31:0] w;
    w = $urandom;
    w[31:25] = hi; w[24:21] = cc; w[15:0] = imm;
    return w;
  endfunction

  function automatic logic [31:0] pick_val();
    case ($urandom % 6)
      0: return 32'hffffffff;
      1: return 32'h80000000;
      2: return 32'h7fffffff;
      3: return $urandom % 8;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [3:0] ccs [10];
    ccs = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'ha, 4'hb, 4'hc, 4'hd};
    void'($urandom(32'd2718));
    rst_n = 1'b0; exe_valid = 1'b0; instr = 32'h0; opa = 32'h0; opb = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #2;
    check("R1", {31'h0, carry}, 32'h0);
    check("R1", {31'h0, flag}, 32'h0);

    // directed corners
    apply(rr(2'd0, 4'h0), 32'hffffffff, 32'h1, 1'b1);         // R2 add wraps, carry 1
    apply(rr(2'd0, 4'h1), 32'h0, 32'h0, 1'b1);                 // R2 carry in consumed
    apply(rr(2'd0, 4'h0), 32'hffffffff, 32'h1, 1'b1);         // R2 carry set again
    apply(rr(2'd0, 4'h2), 32'h5, 32'h7, 1'b1);                 // R3 carry held at 1
    apply(rr(2'd0, 4'h0), 32'h1, 32'h1, 1'b0);                 // R11 idle, no change
    apply(immop(6'h29, 16'h8001), 32'hffffffff, 32'h0, 1'b1);  // R5 zero extend
    apply(immop(6'h2b, 16'h8000), 32'h0, 32'h0, 1'b1);         // R5 sign extend
    apply(immop(6'h27, 16'hffff), 32'h1, 32'h0, 1'b1);         // R5/R2 addi -1
    apply(rr(2'd2, 4'h8), 32'h80000000, 32'h21, 1'b1);        // R6 sra, amount bit5 ignored
    apply(rr(2'd1, 4'h8), 32'h80000000, 32'h21, 1'b1);        // R6 srl
    apply(rr(2'd0, 4'h8), 32'h3, 32'h1f, 1'b1);                // R6 sll
    apply(immop(6'h06, 16'h1234), 32'hdeadbeef, 32'h0, 1'b1);  // R7
    apply(cmpop(7'h72, 4'h4, 16'h0), 32'h1, 32'hffffffff, 1'b1); // R8 ltu true
    apply(cmpop(7'h72, 4'hc, 16'h0), 32'h1, 32'hffffffff, 1'b1); // R8 lts false
    apply(cmpop(7'h5e, 4'h3, 16'hffff), 32'hfffffff0, 32'h0, 1'b1); // R9 geu false
    apply(cmpop(7'h5e, 4'h3, 16'hffff), 32'hffffffff, 32'h0, 1'b1); // R9 geu true
    apply(cmpop(7'h72, 4'h0, 16'h0), 32'h9, 32'h9, 1'b0);      // R11 compare while idle
    apply(rr(2'd0, 4'h6), 32'h1, 32'h2, 1'b1);                 // R12 unlisted selector
    apply(cmpop(7'h72, 4'h7, 16'h0), 32'h0, 32'h0, 1'b1);      // R12 bad condition

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w, a, b;
      a = pick_val();
      b = ($urandom % 4 == 0) ? a : pick_val();
      case ($urandom % 17)
        0:  w = rr(2'd0, 4'h0);
        1:  w = rr(2'd0, 4'h1);
        2:  w = rr(2'd0, 4'h2);
        3:  w = rr(2'd0, 4'h3);
        4:  w = rr(2'd0, 4'h4);
        5:  w = rr(2'd0, 4'h5);
        6:  w = rr(2'd0, 4'h8);
        7:  w = rr(2'd1, 4'h8);
        8:  w = rr(2'd2, 4'h8);
        9:  w = immop(6'h27, 16'($urandom));
        10: w = immop(6'h29, 16'($urandom));
        11: w = immop(6'h2a, 16'($urandom));
        12: w = immop(6'h2b, 16'($urandom));
        13: w = immop(6'h06, 16'($urandom));
        14: w = cmpop(7'h72, ccs[$urandom % 10], 16'($urandom));
        15: begin
          w = cmpop(7'h5e, ccs[$urandom % 10], 16'($urandom));
          if ($urandom % 3 == 0) a = {{16{w[15]}}, w[15:0]};
        end
        default: w = $urandom;
      endcase
      apply(w, a, b, ($urandom % 8) != 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule